// File: doc/BRIEF.md
# Activity-Monitor User-Enable Register and Access Arbiter

This block owns the 64-bit control register that decides whether user-level software may touch a bank of activity-monitor counters. It also rules on every system-register access aimed at that control register. The decoder hands it the current privilege level, the level-2 and level-3 trap controls, and the decoded register encoding with a read/write strobe. Within the same cycle the block answers with one of four outcomes: the access completes, it is an undefined instruction, it is redirected to level 2, or it is redirected to level 3. For a trap it also gives the exception class that the exception-entry logic will report.

A second path gates user-level accesses to the counter registers themselves. While the stored enable bit is clear, such an access is sent to level 1, or to level 2 when level 2 is enabled and its routing flag is set. Once the bit is set, this gate never traps. All decisions are combinational from the inputs. The only state is the enable flop, which updates on the clock edge after a write that completes.

Top module: `mon_access_gate`

## Requirements
- R1: After synchronous reset the enable bit is 0. A completed read then returns 0, and a counter access at level 0 traps to level 1.
- R2: Only the encoding op0=0b11, op1=0b011, CRn=0b1101, CRm=0b0010, op2=0b011 is claimed. Any other encoding gives no undefined, no trap and zero read data, and a write with it leaves the register unchanged.
- R3: A write at level 0 is undefined, whatever the trap controls say.
- R4: At levels 0, 1 and 2, level 3 present with its undefined-priority control set and its trap bit set makes the access undefined, ahead of every other check.
- R5: At levels 0 and 1, when R4 does not apply, level 2 enabled with the level-2 trap bit set traps the access to level 2 (trap level output 2'b10).
- R6: When no earlier check applies, level 3 present with its trap bit set makes the access undefined if the level-3 undefined control is set. Otherwise the access traps to level 3 (trap level output 2'b11).
- R7: At level 2 the level-2 trap bit has no effect. At level 3 every access completes.
- R8: A trap in 64-bit mode reports class 0x18. In 32-bit mode a single-register transfer reports 0x03 and a double-register transfer reports 0x04. Without a trap the class output is 0.
- R9: Only bit 0 is stored. Bits 63:1 read as 0 and writes to them are dropped. The bit takes the write data one edge after a completed write. A trapped or undefined write leaves it unchanged.
- R10: With the enable bit 0, a counter access at level 0 traps to level 1, or to level 2 when level 2 is enabled and the route flag is 1. With the bit 1, or at any other level, the counter gate never traps.
- R11: When the parameter IMPLEMENTED is 0, every access to the encoding is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| l2_enabled | input | 1 | Level 2 implemented and enabled for the current state |
| l3_present | input | 1 | Level 3 implemented |
| l2_trap_bit | input | 1 | Level-2 monitor trap control |
| l3_trap_bit | input | 1 | Level-3 monitor trap control |
| l3_undef_prio | input | 1 | Level-3 control: undefined outranks every trap |
| l3_undef_sel | input | 1 | Level-3 control: undefined instead of a level-3 trap |
| route_to_l2 | input | 1 | Send level-1-bound user traps to level 2 |
| narrow_mode | input | 1 | Access comes from 32-bit mode |
| pair_xfer | input | 1 | 32-bit double-register transfer |
| acc_valid | input | 1 | A system-register access is presented |
| acc_write | input | 1 | 1 = write, 0 = read |
| enc_op0 | input | 2 | Encoding field op0 |
| enc_op1 | input | 3 | Encoding field op1 |
| enc_crn | input | 4 | Encoding field CRn |
| enc_crm | input | 4 | Encoding field CRm |
| enc_op2 | input | 3 | Encoding field op2 |
| wdata | input | 64 | Write data |
| ctr_acc | input | 1 | Access to a counter register is presented |
| rdata | output | 64 | Read data of a completed read, else 0 |
| acc_undef | output | 1 | Access is an undefined instruction |
| acc_trap | output | 1 | Access traps |
| acc_trap_lvl | output | 2 | Trap target level |
| acc_ec | output | 6 | Exception class of the trap |
| ctr_trap | output | 1 | Counter access traps |
| ctr_trap_lvl | output | 2 | Counter trap target level |
| ctr_ec | output | 6 | Counter trap exception class |

## Verification
The hardest situation to reach is a rejected write that lands while the enable bit already holds 1. In that case a missing update guard and a correct design look the same unless the register was set beforehand. The stimulus therefore first sets the bit with a completed level-3 write. It then aims a level-2 trap, a level-0 write of zero and a write of zero with a wrong encoding at the register. A level-3 read after each one shows the bit is still 1. The priority cascade is covered by a vector table in which several trap controls are set together, so that each rung is seen to win over the ones below it.

// File: rtl/mon_gate_pkg.sv
// Package: shared types and constants for the monitor user-enable access block.
// Assumes: privilege levels are encoded 0..3 in two bits.
package mon_gate_pkg;

    // Decoded system-register selector.
    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysenc_t;

    // Outcome of the privilege cascade.
    typedef enum logic [1:0] {
        ACC_OK    = 2'd0,
        ACC_UNDEF = 2'd1,
        ACC_TRAP2 = 2'd2,
        ACC_TRAP3 = 2'd3
    } acc_res_e;

    localparam int EC_W  = 6;
    localparam int LVL_W = 2;

    localparam logic [EC_W-1:0] EC_SYS64    = 6'h18;
    localparam logic [EC_W-1:0] EC_CP_ONE   = 6'h03;
    localparam logic [EC_W-1:0] EC_CP_TWO   = 6'h04;

    localparam logic [LVL_W-1:0] LVL_USER = 2'd0;
    localparam logic [LVL_W-1:0] LVL_KERN = 2'd1;
    localparam logic [LVL_W-1:0] LVL_HYP  = 2'd2;
    localparam logic [LVL_W-1:0] LVL_MON  = 2'd3;

    localparam sysenc_t UEN_ENC = '{op0: 2'b11, op1: 3'b011, crn: 4'b1101,
                                    crm: 4'b0010, op2: 3'b011};

endpackage

// File: rtl/mon_enc_match.sv
// Module: compares the decoded encoding with one fixed selector.
// Assumes: the decoder presents the same field tuple for reads and writes.
module mon_enc_match
    import mon_gate_pkg::*;
#(
    parameter sysenc_t TARGET = UEN_ENC
) (
    input  sysenc_t enc,
    output logic    hit
);

    localparam int ENC_W = $bits(sysenc_t);

    logic [ENC_W-1:0] diff;

    // Purpose: flag each field bit that differs from the target.
    always_comb begin
        diff = enc ^ TARGET;
    end

    // Purpose: the selector matches when no bit differs.
    always_comb begin
        hit = (diff == '0);
    end

endmodule

// File: rtl/mon_priv_cascade.sv
// Module: fixed-priority decision for an access to the enable register.
// Assumes: inputs are stable within the cycle; clk/rst_n serve the checks only.
module mon_priv_cascade
    import mon_gate_pkg::*;
#(
    parameter bit IMPLEMENTED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl,
    input  logic             is_write,
    input  logic             l2_enabled,
    input  logic             l3_present,
    input  logic             l2_trap_bit,
    input  logic             l3_trap_bit,
    input  logic             l3_undef_prio,
    input  logic             l3_undef_sel,
    output acc_res_e         res
);

    logic top_undef;   // rung 1: level-3 undefined outranks all
    logic l2_hit;      // rung 2: level-2 trap
    logic l3_hit;      // rung 3: level-3 trap or undefined

    // Purpose: evaluate each rung condition on its own.
    always_comb begin
        top_undef = l3_present && l3_undef_prio && l3_trap_bit;
        l2_hit    = l2_enabled && l2_trap_bit;
        l3_hit    = l3_present && l3_trap_bit;
    end

    // Purpose: walk the rungs in priority order for the current level.
    always_comb begin
        res = ACC_OK;
        if (!IMPLEMENTED) begin
            res = ACC_UNDEF;
        end else if (is_write && lvl == LVL_USER) begin
            res = ACC_UNDEF;
        end else begin
            unique case (lvl)
                LVL_USER, LVL_KERN: begin
                    if (top_undef)   res = ACC_UNDEF;
                    else if (l2_hit) res = ACC_TRAP2;
                    else if (l3_hit) res = l3_undef_sel ? ACC_UNDEF : ACC_TRAP3;
                    else             res = ACC_OK;
                end
                LVL_HYP: begin
                    if (top_undef)   res = ACC_UNDEF;
                    else if (l3_hit) res = l3_undef_sel ? ACC_UNDEF : ACC_TRAP3;
                    else             res = ACC_OK;
                end
                default: res = ACC_OK;
            endcase
        end
    end

    // R7: the top level always completes when the register exists
    a_r7_top_level_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (IMPLEMENTED && lvl == LVL_MON) |-> res == ACC_OK);

    // R7: level 2 never yields a level-2 trap
    a_r7_hyp_no_self_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LVL_HYP) |-> res != ACC_TRAP2);

    // R4: the undefined-priority rung wins below level 3
    a_r4_prio_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != LVL_MON && l3_present && l3_undef_prio && l3_trap_bit) |-> res == ACC_UNDEF);

    // R3: user-level writes never complete or trap
    a_r3_user_write: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LVL_USER && is_write) |-> res == ACC_UNDEF);

endmodule

// File: rtl/mon_ec_select.sv
// Module: picks the exception class reported for a trap.
// Assumes: pair_xfer is only meaningful in 32-bit mode.
module mon_ec_select
    import mon_gate_pkg::*;
(
    input  logic            narrow_mode,
    input  logic            pair_xfer,
    output logic [EC_W-1:0] ec
);

    // Purpose: map execution mode and transfer width to a class code.
    always_comb begin
        if (!narrow_mode)   ec = EC_SYS64;
        else if (pair_xfer) ec = EC_CP_TWO;
        else                ec = EC_CP_ONE;
    end

endmodule

// File: rtl/mon_uen_reg.sv
// Module: storage for the user-enable register; one live bit, rest read zero.
// Assumes: wr_en is already qualified by the access decision.
module mon_uen_reg #(
    parameter int REG_W  = 64,
    parameter int EN_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bit,
    output logic [REG_W-1:0] rd_val,
    output logic             en
);

    logic en_q;

    // Purpose: hold the enable bit; cleared by reset, loaded on a completed write.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (wr_en) en_q <= wr_bit;
    end

    // Purpose: build the read image, reserved positions fixed at zero.
    for (genvar gi = 0; gi < REG_W; gi++) begin : g_bits
        if (gi == EN_BIT) begin : g_live
            assign rd_val[gi] = en_q;
        end else begin : g_res0
            assign rd_val[gi] = 1'b0;
        end
    end

    assign en = en_q;

    // R9: a write that did not complete keeps the bit
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));

    // R9: a completed write lands one edge later
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> en_q == $past(wr_bit));

endmodule

// File: rtl/mon_user_gate.sv
// Module: decides whether a user-level counter access is pushed up a level.
// Assumes: ctr_acc is raised for counter-register accesses only.
module mon_user_gate
    import mon_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [LVL_W-1:0] lvl,
    input  logic             ctr_acc,
    input  logic             l2_enabled,
    input  logic             route_to_l2,
    output logic             trap,
    output logic [LVL_W-1:0] trap_lvl
);

    // Purpose: trap user counter access while disabled, choose target.
    always_comb begin
        trap     = ctr_acc && (lvl == LVL_USER) && !en;
        trap_lvl = '0;
        if (trap) trap_lvl = (l2_enabled && route_to_l2) ? LVL_HYP : LVL_KERN;
    end

    // R10: once enabled the gate is silent
    a_r10_enabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> !trap);

    // R10: a trap targets level 1 or 2 only
    a_r10_target_range: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (trap_lvl == LVL_KERN || trap_lvl == LVL_HYP));

endmodule

// File: rtl/mon_access_gate.sv
// Module: top of the monitor user-enable block; ties decision, storage and gate.
// Assumes: inputs arrive from registers; outputs are combinational.
module mon_access_gate
    import mon_gate_pkg::*;
#(
    parameter int REG_W       = 64,
    parameter int EN_BIT      = 0,
    parameter bit IMPLEMENTED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cur_lvl,
    input  logic             l2_enabled,
    input  logic             l3_present,
    input  logic             l2_trap_bit,
    input  logic             l3_trap_bit,
    input  logic             l3_undef_prio,
    input  logic             l3_undef_sel,
    input  logic             route_to_l2,
    input  logic             narrow_mode,
    input  logic             pair_xfer,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [1:0]       enc_op0,
    input  logic [2:0]       enc_op1,
    input  logic [3:0]       enc_crn,
    input  logic [3:0]       enc_crm,
    input  logic [2:0]       enc_op2,
    input  logic [REG_W-1:0] wdata,
    input  logic             ctr_acc,
    output logic [REG_W-1:0] rdata,
    output logic             acc_undef,
    output logic             acc_trap,
    output logic [1:0]       acc_trap_lvl,
    output logic [5:0]       acc_ec,
    output logic             ctr_trap,
    output logic [1:0]       ctr_trap_lvl,
    output logic [5:0]       ctr_ec
);

    sysenc_t          enc;
    logic             enc_hit;
    logic             claimed;
    acc_res_e         res;
    logic [EC_W-1:0]  ec;
    logic             wr_ok;
    logic             rd_ok;
    logic [REG_W-1:0] reg_img;
    logic             en;
    logic [REG_W-1:0] wdata_unused_bits;

    // Purpose: gather the encoding fields into one selector.
    always_comb begin
        enc = '{op0: enc_op0, op1: enc_op1, crn: enc_crn, crm: enc_crm, op2: enc_op2};
    end

    mon_enc_match #(.TARGET(UEN_ENC)) u_match (
        .enc (enc),
        .hit (enc_hit)
    );

    mon_priv_cascade #(.IMPLEMENTED(IMPLEMENTED)) u_cascade (
        .clk           (clk),
        .rst_n         (rst_n),
        .lvl           (cur_lvl),
        .is_write      (acc_write),
        .l2_enabled    (l2_enabled),
        .l3_present    (l3_present),
        .l2_trap_bit   (l2_trap_bit),
        .l3_trap_bit   (l3_trap_bit),
        .l3_undef_prio (l3_undef_prio),
        .l3_undef_sel  (l3_undef_sel),
        .res           (res)
    );

    mon_ec_select u_ec (
        .narrow_mode (narrow_mode),
        .pair_xfer   (pair_xfer),
        .ec          (ec)
    );

    // Purpose: qualify the cascade result with a claimed access.
    always_comb begin
        claimed      = acc_valid && enc_hit;
        acc_undef    = claimed && (res == ACC_UNDEF);
        acc_trap     = claimed && (res == ACC_TRAP2 || res == ACC_TRAP3);
        acc_trap_lvl = '0;
        if (claimed && res == ACC_TRAP2) acc_trap_lvl = LVL_HYP;
        if (claimed && res == ACC_TRAP3) acc_trap_lvl = LVL_MON;
        acc_ec       = acc_trap ? ec : '0;
        wr_ok        = claimed && acc_write  && (res == ACC_OK);
        rd_ok        = claimed && !acc_write && (res == ACC_OK);
    end

    // Purpose: mark the reserved write bits as deliberately dropped.
    always_comb begin
        wdata_unused_bits         = wdata;
        wdata_unused_bits[EN_BIT] = 1'b0;
    end

    mon_uen_reg #(.REG_W(REG_W), .EN_BIT(EN_BIT)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ok),
        .wr_bit (wdata[EN_BIT]),
        .rd_val (reg_img),
        .en     (en)
    );

    // Purpose: drive read data only for a completed read.
    always_comb begin
        rdata = rd_ok ? reg_img : '0;
    end

    mon_user_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .lvl         (cur_lvl),
        .ctr_acc     (ctr_acc),
        .l2_enabled  (l2_enabled),
        .route_to_l2 (route_to_l2),
        .trap        (ctr_trap),
        .trap_lvl    (ctr_trap_lvl)
    );

    // Purpose: report the class of a counter trap.
    always_comb begin
        ctr_ec = ctr_trap ? ec : '0;
    end

    // R2: unclaimed encodings produce nothing
    a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !enc_hit) |-> (!acc_undef && !acc_trap && rdata == '0));

    // R6: undefined and trap never coincide
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_undef && acc_trap));

    // R8: 64-bit traps report the system-access class
    a_r8_wide_class: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_trap && !narrow_mode) |-> acc_ec == EC_SYS64);

    // R9: reserved read positions stay zero
    a_r9_res0_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~(REG_W'(1) << EN_BIT)) == '0);

    // R11: absent register makes every claimed access undefined
    a_r11_absent: assert property (@(posedge clk) disable iff (!rst_n)
        (!IMPLEMENTED && claimed) |-> acc_undef);

endmodule

// File: tb/sim_mon_access_gate.sv
`timescale 1ns/1ps
module sim_mon_access_gate;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cur_lvl = '0;
    logic l2_enabled = 0, l3_present = 0, l2_trap_bit = 0, l3_trap_bit = 0;
    logic l3_undef_prio = 0, l3_undef_sel = 0, route_to_l2 = 0;
    logic narrow_mode = 0, pair_xfer = 0, acc_valid = 0, acc_write = 0;
    logic [1:0] enc_op0 = 2'b11;
    logic [2:0] enc_op1 = 3'b011;
    logic [3:0] enc_crn = 4'b1101;
    logic [3:0] enc_crm = 4'b0010;
    logic [2:0] enc_op2 = 3'b011;
    logic [63:0] wdata = '0;
    logic ctr_acc = 0;

    logic [63:0] rdata, rdata1;
    logic acc_undef, acc_trap, ctr_trap, acc_undef1, acc_trap1, ctr_trap1;
    logic [1:0] acc_trap_lvl, ctr_trap_lvl, acc_trap_lvl1, ctr_trap_lvl1;
    logic [5:0] acc_ec, ctr_ec, acc_ec1, ctr_ec1;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mon_access_gate u0 (
        .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .l2_enabled(l2_enabled),
        .l3_present(l3_present), .l2_trap_bit(l2_trap_bit), .l3_trap_bit(l3_trap_bit),
        .l3_undef_prio(l3_undef_prio), .l3_undef_sel(l3_undef_sel),
        .route_to_l2(route_to_l2), .narrow_mode(narrow_mode), .pair_xfer(pair_xfer),
        .acc_valid(acc_valid), .acc_write(acc_write), .enc_op0(enc_op0),
        .enc_op1(enc_op1), .enc_crn(enc_crn), .enc_crm(enc_crm), .enc_op2(enc_op2),
        .wdata(wdata), .ctr_acc(ctr_acc), .rdata(rdata), .acc_undef(acc_undef),
        .acc_trap(acc_trap), .acc_trap_lvl(acc_trap_lvl), .acc_ec(acc_ec),
        .ctr_trap(ctr_trap), .ctr_trap_lvl(ctr_trap_lvl), .ctr_ec(ctr_ec)
    );

    mon_access_gate #(.IMPLEMENTED(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .l2_enabled(l2_enabled),
        .l3_present(l3_present), .l2_trap_bit(l2_trap_bit), .l3_trap_bit(l3_trap_bit),
        .l3_undef_prio(l3_undef_prio), .l3_undef_sel(l3_undef_sel),
        .route_to_l2(route_to_l2), .narrow_mode(narrow_mode), .pair_xfer(pair_xfer),
        .acc_valid(acc_valid), .acc_write(acc_write), .enc_op0(enc_op0),
        .enc_op1(enc_op1), .enc_crn(enc_crn), .enc_crm(enc_crm), .enc_op2(enc_op2),
        .wdata(wdata), .ctr_acc(ctr_acc), .rdata(rdata1), .acc_undef(acc_undef1),
        .acc_trap(acc_trap1), .acc_trap_lvl(acc_trap_lvl1), .acc_ec(acc_ec1),
        .ctr_trap(ctr_trap1), .ctr_trap_lvl(ctr_trap_lvl1), .ctr_ec(ctr_ec1)
    );

    // Vector: {lvl[2], wr, l2en, l3p, t2, t3, uprio, usel, exp_undef, exp_trap, exp_lvl[2]}
    localparam int NV = 16;
    localparam logic [12:0] VEC [NV] = '{
        13'b00_0_000000_0000,   // R7 base: plain read completes
        13'b00_0_010110_1000,   // R4 priority undefined
        13'b00_0_111110_1000,   // R4 wins over level-2 trap
        13'b00_0_111100_0110,   // R5 level-2 trap beats level-3
        13'b01_0_010100_0111,   // R6 trap to level 3
        13'b01_0_010101_1000,   // R6 undefined via select
        13'b01_1_101000_0110,   // R5 write traps to level 2
        13'b01_0_001000_0000,   // R5 level 2 disabled: no trap
        13'b10_0_101000_0000,   // R7 level 2 ignores its trap bit
        13'b10_1_111100_0111,   // R7 level 2 only sees level-3 rungs
        13'b10_0_010110_1000,   // R4 at level 2
        13'b11_1_111111_0000,   // R7 level 3 always completes
        13'b00_1_000000_1000,   // R3 user write undefined
        13'b00_1_101000_1000,   // R3 user write beats level-2 trap
        13'b01_0_000111_0000,   // R6 level 3 absent: controls inert
        13'b00_0_101000_0110    // R5 user read traps to level 2
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] lvl, input logic wr, input logic l2e,
                         input logic l3p, input logic t2, input logic t3,
                         input logic up, input logic us, input logic [63:0] wd);
        acc_valid = 1; acc_write = wr; cur_lvl = lvl;
        l2_enabled = l2e; l3_present = l3p; l2_trap_bit = t2; l3_trap_bit = t3;
        l3_undef_prio = up; l3_undef_sel = us; wdata = wd;
        narrow_mode = 0; pair_xfer = 0; ctr_acc = 0; route_to_l2 = 0;
        enc_crm = 4'b0010;
    endtask

    task automatic idle();
        acc_valid = 0; acc_write = 0; ctr_acc = 0; cur_lvl = 0;
        l2_enabled = 0; l3_present = 0; l2_trap_bit = 0; l3_trap_bit = 0;
        l3_undef_prio = 0; l3_undef_sel = 0; route_to_l2 = 0;
        narrow_mode = 0; pair_xfer = 0; wdata = '0; enc_crm = 4'b0010;
    endtask

    task automatic read_check(input string req, input logic [63:0] exp);
        @(negedge clk);
        drive(2'd3, 0, 0, 0, 0, 0, 0, 0, '0);
        #1 check(req, rdata, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: read after reset returns zero
        read_check("R1 reset read", 64'h0);
        // R1 / R10: counter access traps to level 1 out of reset
        @(negedge clk); idle(); ctr_acc = 1;
        #1 check("R1 reset ctr trap {trap,lvl,ec}", {ctr_trap, ctr_trap_lvl, ctr_ec},
                 {1'b1, 2'd1, 6'h18});

        // Cascade table: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][12:11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7],
                  VEC[i][6], VEC[i][5], VEC[i][4], '0);
            #1 check($sformatf("R4 R5 R6 R7 cascade vec %0d {undef,trap,lvl,ec}", i),
                     {acc_undef, acc_trap, acc_trap_lvl, acc_ec},
                     {VEC[i][3], VEC[i][2], VEC[i][1:0], VEC[i][2] ? 6'h18 : 6'h00});
        end

        // R9: write all ones at level 3, only bit 0 reads back
        @(negedge clk); drive(2'd3, 1, 0, 0, 0, 0, 0, 0, '1);
        #1 check("R9 write completes", {acc_undef, acc_trap}, 2'b00);
        read_check("R9 reserved bits zero", 64'h1);

        // R10: enabled bit silences the counter gate
        @(negedge clk); idle(); ctr_acc = 1;
        #1 check("R10 enabled no ctr trap", ctr_trap, 1'b0);

        // R9: trapped write leaves bit set
        @(negedge clk); drive(2'd1, 1, 1, 0, 1, 0, 0, 0, '0);
        #1 check("R9 trapped write traps", acc_trap, 1'b1);
        read_check("R9 trapped write kept bit", 64'h1);

        // R3 / R9: user write of zero is undefined and dropped
        @(negedge clk); drive(2'd0, 1, 0, 0, 0, 0, 0, 0, '0);
        #1 check("R3 user write undefined", acc_undef, 1'b1);
        read_check("R9 undefined write kept bit", 64'h1);

        // R2: other encoding ignored
        @(negedge clk); drive(2'd3, 1, 0, 0, 0, 0, 0, 0, '0); enc_crm = 4'b0011;
        #1 check("R2 miss quiet {undef,trap,rdata}", {acc_undef, acc_trap, rdata}, 66'h0);
        read_check("R2 miss write dropped", 64'h1);

        // R9: completed write of zero at level 1
        @(negedge clk); drive(2'd1, 1, 0, 0, 0, 0, 0, 0, '0);
        read_check("R9 clear bit", 64'h0);

        // R10: routing of counter traps
        @(negedge clk); idle(); ctr_acc = 1; l2_enabled = 1; route_to_l2 = 1;
        #1 check("R10 route to level 2", {ctr_trap, ctr_trap_lvl}, {1'b1, 2'd2});
        @(negedge clk); l2_enabled = 0;
        #1 check("R10 route needs level 2", {ctr_trap, ctr_trap_lvl}, {1'b1, 2'd1});
        @(negedge clk); cur_lvl = 2'd1;
        #1 check("R10 non-user level no trap", ctr_trap, 1'b0);

        // R8: 32-bit classes
        @(negedge clk); drive(2'd1, 0, 1, 0, 1, 0, 0, 0, '0); narrow_mode = 1;
        #1 check("R8 single transfer class", acc_ec, 64'h03);
        @(negedge clk); pair_xfer = 1;
        #1 check("R8 double transfer class", acc_ec, 64'h04);
        @(negedge clk); idle(); ctr_acc = 1; narrow_mode = 1; pair_xfer = 1;
        #1 check("R8 counter double class", ctr_ec, 64'h04);

        // R11: absent register is undefined even at level 3
        @(negedge clk); drive(2'd3, 0, 0, 0, 0, 0, 0, 0, '0);
        #1 check("R11 absent undefined", {acc_undef1, rdata1}, {1'b1, 64'h0});

        // R1: reset clears a set bit
        @(negedge clk); drive(2'd3, 1, 0, 0, 0, 0, 0, 0, 64'h1);
        read_check("R1 set before reset", 64'h1);
        @(negedge clk); idle(); rst_n = 0;
        @(negedge clk); rst_n = 1;
        read_check("R1 reset clears bit", 64'h0);

        @(negedge clk); idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule